// File: doc/BRIEF.md
# Dual-Channel Converter Serial Command Decoder

This block is the digital front end of a two-channel 8-bit converter. A host drives a three-wire synchronous serial link made of an active-low select, a serial clock and a data input. The block shifts each frame in, splits it into a 2-bit channel address, a 2-bit power-down field and an 8-bit code, and updates two channel code registers, the power-down state and one output-enable flag per channel. These values leave the block as parallel outputs for the analog section.

A return data line carries the input stream back to the host, delayed by twelve and a half serial clock periods. It changes only on falling serial clock edges and always drives a level. The serial pins are oversampled by the block's own clock. Serial clock edges are found by comparing consecutive samples, so the serial clock has to be several times slower than the block clock. A decoded frame takes effect when select is released.

Top module: `dacfe_top`

## Requirements
- R1: After reset both channel codes are 0, all three power-down outputs are 0, both enable flags are 0 and `dout` is 0.
- R2: A frame is shifted in MSB first as A1 A0 P1 P0 D7..D0. It is applied on the rising edge of `csN`. Address 01 loads the code into channel A.
- R3: Address 10 loads the code into channel B only. Address 11 loads the same code into both channels.
- R4: Address 00 is a no-op. The codes, the power-down state and both enable flags stay unchanged whatever the other bits are.
- R5: A frame with a non-zero address also replaces the power-down state with P1 P0. 00 is normal, 01 powers down A (`pdA`=1), 10 powers down B (`pdB`=1), and 11 powers down both with `pdAll`=1.
- R6: When more than 12 bits arrive in one select period, only the last 12 are decoded. A 16-bit frame therefore has its first four bits ignored.
- R7: A select period that clocks in fewer than 12 bits changes no register.
- R8: A channel's enable flag is set when that channel is written and the frame does not power it down. A frame that powers a channel down clears its flag. Otherwise the flag holds.
- R9: After each falling serial clock edge while selected, `dout` equals the bit sampled 12 rising edges earlier in the stream since reset, or 0 if fewer than 13 bits were sampled.
- R10: While `csN` is high, serial clock edges and `din` are ignored. `dout` holds its value and no bit enters the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idles low |
| csN | input | 1 | Active-low select, frame applied on its rising edge |
| din | input | 1 | Serial data in, sampled on rising sclk |
| dout | output | 1 | Delayed echo of the input stream |
| codeA | output | 8 | Channel A code |
| codeB | output | 8 | Channel B code |
| enA | output | 1 | Channel A output enable |
| enB | output | 1 | Channel B output enable |
| pdA | output | 1 | Channel A powered down |
| pdB | output | 1 | Channel B powered down |
| pdAll | output | 1 | Whole device powered down |

## Verification
The decoder is driven with frames for each of the four addresses, using distinct bit patterns in the code. This separates a swapped channel select, a missed broadcast, and a no-op that leaks into the registers. A sequence of power-down frames follows that powers channels down, swaps which one is down, and releases both again. It shows whether power-down is applied together with the data and whether enables are set only by a write. A 9-bit frame and a 16-bit frame with a leading nibble of ones test which bits get decoded. Echo checks after every falling edge across all frames, plus clock pulses with select high, confirm the 12.5-period delay and that no unselected edge gets into the stream.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  typedef struct packed {
    logic shiftEn;
    logic echoEn;
    logic commit;
    logic bitIn;
  } strobe_t;

  typedef enum logic [1:0] {
    ADDR_NOP = 2'b00,
    ADDR_A   = 2'b01,
    ADDR_B   = 2'b10,
    ADDR_AB  = 2'b11
  } addr_e;
endpackage

// File: rtl/dacfe_ctrl.sv
module dacfe_ctrl
  import dacfe_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclk,
  input  logic    csN,
  input  logic    din,
  output strobe_t st
);
  localparam int FRAME_W = CODE_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic sclkQ, sclkPrev, csNQ, csNPrev, dinQ;
  logic [CNT_W-1:0] bitCnt;
  logic sclkRise, sclkFall, csRise, csFall, frameFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ    <= 1'b0;
      sclkPrev <= 1'b0;
      csNQ     <= 1'b1;
      csNPrev  <= 1'b1;
      dinQ     <= 1'b0;
    end else begin
      sclkQ    <= sclk;
      sclkPrev <= sclkQ;
      csNQ     <= csN;
      csNPrev  <= csNQ;
      dinQ     <= din;
    end
  end

  assign sclkRise  = sclkQ & ~sclkPrev;
  assign sclkFall  = ~sclkQ & sclkPrev;
  assign csRise    = csNQ & ~csNPrev;
  assign csFall    = ~csNQ & csNPrev;
  assign frameFull = (bitCnt == CNT_W'(FRAME_W));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (csFall) begin
      bitCnt <= '0;
    end else if (!csNQ && sclkRise && !frameFull) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    st.shiftEn = sclkRise & ~csNQ;
    st.echoEn  = sclkFall & ~csNQ;
    st.commit  = csRise & frameFull;
    st.bitIn   = dinQ;
  end

  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    csNQ |=> $stable(bitCnt));

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(FRAME_W));
endmodule

// File: rtl/dacfe_dp.sv
module dacfe_dp
  import dacfe_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int ECHO_DELAY = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  output logic              dout,
  output logic [CODE_W-1:0] codeA,
  output logic [CODE_W-1:0] codeB,
  output logic              enA,
  output logic              enB,
  output logic              pdA,
  output logic              pdB,
  output logic              pdAll
);
  localparam int FRAME_W = CODE_W + 4;
  localparam int SH_W    = (ECHO_DELAY + 1 > FRAME_W) ? ECHO_DELAY + 1 : FRAME_W;
  localparam int NCH     = 2;

  logic [SH_W-1:0]   shReg;
  logic [1:0]        pdState;
  logic [CODE_W-1:0] chanCode [NCH];
  logic [NCH-1:0]    chanEn;
  logic [1:0]        addrF, pdF;
  logic [CODE_W-1:0] codeF;
  logic              applyFrame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else if (st.shiftEn) shReg <= {shReg[SH_W-2:0], st.bitIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dout <= 1'b0;
    else if (st.echoEn) dout <= shReg[ECHO_DELAY];
  end

  assign addrF      = shReg[FRAME_W-1 -: 2];
  assign pdF        = shReg[FRAME_W-3 -: 2];
  assign codeF      = shReg[CODE_W-1:0];
  assign applyFrame = st.commit && (addr_e'(addrF) != ADDR_NOP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pdState <= 2'b00;
    else if (applyFrame) pdState <= pdF;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chanCode[ch] <= '0;
        chanEn[ch]   <= 1'b0;
      end else if (applyFrame) begin
        if (addrF[ch]) chanCode[ch] <= codeF;
        if (pdF[ch]) chanEn[ch] <= 1'b0;
        else if (addrF[ch]) chanEn[ch] <= 1'b1;
      end
    end
  end

  assign codeA = chanCode[0];
  assign codeB = chanCode[1];
  assign enA   = chanEn[0];
  assign enB   = chanEn[1];
  assign pdA   = pdState[0];
  assign pdB   = pdState[1];
  assign pdAll = &pdState;

  // R8
  en_vs_pd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(enA && pdA) && !(enB && pdB));

  // R9
  echo_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.echoEn |=> $stable(dout));

  // R4
  noop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.commit && addrF == 2'b00) |=> ($stable(codeA) && $stable(codeB) &&
      $stable(pdA) && $stable(pdB) && $stable(enA) && $stable(enB)));

  // R2
  code_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.commit |=> ($stable(codeA) && $stable(codeB)));
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
  import dacfe_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int ECHO_DELAY = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              din,
  output logic              dout,
  output logic [CODE_W-1:0] codeA,
  output logic [CODE_W-1:0] codeB,
  output logic              enA,
  output logic              enB,
  output logic              pdA,
  output logic              pdB,
  output logic              pdAll
);
  strobe_t st;

  dacfe_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .din(din), .st(st)
  );

  dacfe_dp #(.CODE_W(CODE_W), .ECHO_DELAY(ECHO_DELAY)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .dout(dout),
    .codeA(codeA), .codeB(codeB), .enA(enA), .enB(enB),
    .pdA(pdA), .pdB(pdB), .pdAll(pdAll)
  );
endmodule

// File: tb/dacfe_top_tb.sv
module dacfe_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic csN = 1'b1;
  logic din = 1'b0;
  logic dout, enA, enB, pdA, pdB, pdAll;
  logic [7:0] codeA, codeB;

  int errCnt = 0;
  int chkCnt = 0;

  logic [7:0] mA = '0, mB = '0;
  logic [1:0] mPd = '0;
  logic mEnA = 1'b0, mEnB = 1'b0;
  logic hist [0:4095];
  int histN = 0;

  always #5 clk = ~clk;

  dacfe_top u_dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .din(din), .dout(dout),
    .codeA(codeA), .codeB(codeB), .enA(enA), .enB(enB),
    .pdA(pdA), .pdB(pdB), .pdAll(pdAll)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkRegs(string tag);
    check({tag, " codeA"}, 16'(codeA), 16'(mA));
    check({tag, " codeB"}, 16'(codeB), 16'(mB));
    check({tag, " en"}, 16'({enB, enA}), 16'({mEnB, mEnA}));
    check({tag, " pd"}, 16'({pdAll, pdB, pdA}), 16'({&mPd, mPd[1], mPd[0]}));
  endtask

  function automatic logic expEcho();
    return (histN >= 13) ? hist[histN-13] : 1'b0;
  endfunction

  // model of the decode rules R2..R5, R8
  task automatic applyModel(logic [11:0] f);
    logic [1:0] a = f[11:10];
    logic [1:0] p = f[9:8];
    if (a != 2'b00) begin
      mPd = p;
      if (a[0]) mA = f[7:0];
      if (a[1]) mB = f[7:0];
      if (p[0]) mEnA = 1'b0; else if (a[0]) mEnA = 1'b1;
      if (p[1]) mEnB = 1'b0; else if (a[1]) mEnB = 1'b1;
    end
  endtask

  task automatic sendBits(logic [15:0] bits, int n, string tag);
    @(negedge clk); csN = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      din = bits[i];
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      hist[histN] = bits[i];
      histN++;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (3) @(negedge clk);
      check({tag, " R9 echo"}, 16'(dout), 16'(expEcho()));
    end
    repeat (2) @(negedge clk);
    csN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic sendFrame(logic [11:0] f, string tag);
    sendBits({4'b0000, f}, 12, tag);
    applyModel(f);
    checkRegs(tag);
  endtask

  task automatic t_reset();
    checkRegs("R1 reset");
    check("R1 dout", 16'(dout), 16'h0);
  endtask

  task automatic t_writes();
    sendFrame({2'b01, 2'b00, 8'h5A}, "R2 writeA");
    sendFrame({2'b10, 2'b00, 8'hC3}, "R3 writeB");
    sendFrame({2'b11, 2'b00, 8'h7E}, "R3 writeBoth");
  endtask

  task automatic t_noop();
    sendFrame({2'b00, 2'b11, 8'hFF}, "R4 noop");
  endtask

  task automatic t_powerDown();
    sendFrame({2'b01, 2'b01, 8'h11}, "R5 R8 pdA");
    sendFrame({2'b10, 2'b10, 8'h22}, "R5 R8 pdB");
    sendFrame({2'b11, 2'b11, 8'h33}, "R5 pdAll");
    sendFrame({2'b01, 2'b00, 8'h44}, "R8 reenableA");
  endtask

  task automatic t_short();
    sendBits(16'h01FF, 9, "R7 short");
    checkRegs("R7 short");
  endtask

  task automatic t_long();
    sendBits({4'b1111, 2'b01, 2'b00, 8'h96}, 16, "R6 long");
    applyModel({2'b01, 2'b00, 8'h96});
    checkRegs("R6 long");
  endtask

  task automatic t_csHigh();
    logic held;
    held = dout;
    for (int i = 0; i < 6; i++) begin
      din = ~din;
      repeat (4) @(negedge clk); sclk = 1'b1;
      repeat (4) @(negedge clk); sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    check("R10 dout hold", 16'(dout), 16'(held));
    checkRegs("R10 regs");
    sendFrame({2'b10, 2'b00, 8'hA5}, "R10 after");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_writes();
    t_noop();
    t_powerDown();
    t_short();
    t_long();
    t_csHigh();
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule